// File: doc/BRIEF.md
# Shared-Memory Access Arbiter

This block decides which of two masters may use a shared on-board memory: the processor on the same board, or a master on another board that reaches the memory over the backplane. Each request enters through its own pin and may change at any moment relative to the arbiter clock. The arbiter clock is the local processor's clock. Each request first passes through a flop synchronizer. It must then stay high at the synchronizer output for a fixed number of extra cycles before the decision logic may use it. The response time is therefore set by the settling allowance, not by how fast the decision logic could react.

Exactly one side owns the memory at a time. An owner keeps its grant until it lowers its request. Then at least one cycle passes with no grant before the memory changes hands. When both sides are waiting in the same cycle, the winner alternates. The `busy` output tells the memory controller that the array is in use. The request pins carry no data, so they are plain level signals with no valid/ready handshake. A master raises its request and holds it until it sees its grant and has finished its access, and only then lowers it.

Top module: `dpa_mem_arbiter`

## Requirements
- R1: `gnt_local` and `gnt_remote` are never high in the same cycle.
- R2: From an idle arbiter with only one side requesting, that side's grant rises exactly SYNC_STAGES+SETTLE_CYCLES+1 rising edges after the edge that first samples its request high. With the defaults this is the 6th edge, so 60 ns at 100 MHz. No grant rises earlier.
- R3: A request sampled high by fewer than SETTLE_CYCLES+1 consecutive edges (3 or fewer with defaults) never produces a grant.
- R4: A grant stays high while its request stays high. It falls SYNC_STAGES+1 edges after the first edge that samples the request low.
- R5: After a grant falls, at least one full cycle with no grant follows. If the other side is already qualified and waiting, its grant rises on the very next edge after that single idle cycle.
- R6: If both requests are qualified in the same idle cycle, the side favoured by a preference bit wins. The preference points to local after reset. Each grant sets the preference to the opposite side of the one granted.
- R7: `busy` is high exactly in the cycles in which one of the two grants is high.
- R8: While `rst_n` is low, all outputs are low at once, independent of the clock. After reset the preference points to local.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock, in step with the local processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_local | input | 1 | Asynchronous memory request from the on-board processor |
| req_remote | input | 1 | Asynchronous memory request from the backplane master |
| gnt_local | output | 1 | Memory granted to the on-board processor |
| gnt_remote | output | 1 | Memory granted to the backplane master |
| busy | output | 1 | Memory currently owned by one of the two sides |

## Verification
The assertions assume that a master raises its request and holds it until it is granted and done, then lowers it. They also assume that a request pin, once settled, does not glitch within the settling window. The bench changes the request pins only at the falling clock edge, so each level is sampled cleanly by the first synchronizer flop. Several cases deliberately use short pulses and overlapping or simultaneous rises to probe the qualification filter and the tie rule. Metastability itself cannot be modelled in simulation. The checks cover only the timing that the synchronizer and settle counter impose.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE   = 2'd0,
    ARB_LOCAL  = 2'd1,
    ARB_REMOTE = 2'd2
  } arb_state_e;

  localparam int SIDES = 2;
  localparam int SIDE_LOCAL = 0;
  localparam int SIDE_REMOTE = 1;
endpackage

// File: rtl/dpa_sync.sv
module dpa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dpa_settle.sv
module dpa_settle #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic qual_o
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!sync_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = sync_i && (cnt_q == LIMIT);

  // R3
  qual_needs_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_o) |-> $past(sync_i));
endmodule

// File: rtl/dpa_decide.sv
module dpa_decide
  import dpa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic qual_l_i,
  input  logic qual_r_i,
  output logic gnt_l_o,
  output logic gnt_r_o,
  output logic busy_o
);
  arb_state_e st_q, st_d;
  logic pref_remote_q, pref_remote_d;

  always_comb begin
    st_d = st_q;
    pref_remote_d = pref_remote_q;
    unique case (st_q)
      ARB_IDLE: begin
        if (qual_l_i && (!qual_r_i || !pref_remote_q)) begin
          st_d = ARB_LOCAL;
          pref_remote_d = 1'b1;
        end else if (qual_r_i) begin
          st_d = ARB_REMOTE;
          pref_remote_d = 1'b0;
        end
      end
      ARB_LOCAL:  if (!qual_l_i) st_d = ARB_IDLE;
      ARB_REMOTE: if (!qual_r_i) st_d = ARB_IDLE;
      default:    st_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ARB_IDLE;
      pref_remote_q <= 1'b0;
      gnt_l_o <= 1'b0;
      gnt_r_o <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      st_q <= st_d;
      pref_remote_q <= pref_remote_d;
      gnt_l_o <= (st_d == ARB_LOCAL);
      gnt_r_o <= (st_d == ARB_REMOTE);
      busy_o <= (st_d != ARB_IDLE);
    end
  end

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_l_o, gnt_r_o}));
  // R2
  gnt_l_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_l_o) |-> $past(qual_l_i));
  // R2
  gnt_r_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_r_o) |-> $past(qual_r_i));
  // R4
  hold_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_l_o && qual_l_i) |=> gnt_l_o);
  // R4
  hold_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_r_o && qual_r_i) |=> gnt_r_o);
  // R5
  gap_after_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnt_l_o) |-> !gnt_r_o);
  // R5
  gap_after_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnt_r_o) |-> !gnt_l_o);
  // R6
  tie_pref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_IDLE && qual_l_i && qual_r_i) |=> (gnt_r_o == $past(pref_remote_q)));
  // R7
  busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == (gnt_l_o || gnt_r_o));
endmodule

// File: rtl/dpa_mem_arbiter.sv
module dpa_mem_arbiter
  import dpa_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_local,
  input  logic req_remote,
  output logic gnt_local,
  output logic gnt_remote,
  output logic busy
);
  logic [SIDES-1:0] req_async;
  logic [SIDES-1:0] req_sync;
  logic [SIDES-1:0] req_qual;

  assign req_async[SIDE_LOCAL]  = req_local;
  assign req_async[SIDE_REMOTE] = req_remote;

  for (genvar i = 0; i < SIDES; i++) begin : g_lane
    dpa_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_i(req_async[i]), .sync_o(req_sync[i])
    );
    dpa_settle #(.SETTLE(SETTLE_CYCLES)) settle_i (
      .clk(clk), .rst_n(rst_n), .sync_i(req_sync[i]), .qual_o(req_qual[i])
    );
  end

  dpa_decide decide_i (
    .clk(clk), .rst_n(rst_n),
    .qual_l_i(req_qual[SIDE_LOCAL]), .qual_r_i(req_qual[SIDE_REMOTE]),
    .gnt_l_o(gnt_local), .gnt_r_o(gnt_remote), .busy_o(busy)
  );

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!gnt_local && !gnt_remote && !busy));
endmodule

// File: tb/dpa_mem_arbiter_tb.sv
module dpa_mem_arbiter_tb_top;
  localparam int SYNC_STAGES = 2;
  localparam int SETTLE_CYCLES = 3;
  localparam int LAT = SYNC_STAGES + SETTLE_CYCLES + 1;
  localparam int RUN = 40;
  localparam int NV = 8;
  // dl, hl, dr, hr, side1, cyc1, fall1, side2, cyc2  (side 0 none, 1 local, 2 remote)
  localparam int VEC [NV][9] = '{
    '{2, 8, 0, 0, 1, 8, 13, 0, 0},
    '{0, 0, 3, 6, 2, 9, 12, 0, 0},
    '{2, 6, 2, 10, 1, 8, 11, 2, 12},
    '{2, 3, 0, 0, 0, 0, 0, 0, 0},
    '{2, 10, 4, 12, 1, 8, 15, 2, 16},
    '{3, 8, 1, 5, 2, 7, 9, 1, 10},
    '{2, 4, 0, 0, 1, 8, 9, 0, 0},
    '{6, 6, 5, 3, 1, 12, 15, 0, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_local = 1'b0;
  logic req_remote = 1'b0;
  logic gnt_local, gnt_remote, busy;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dpa_mem_arbiter #(.SYNC_STAGES(SYNC_STAGES), .SETTLE_CYCLES(SETTLE_CYCLES)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_local(req_local), .req_remote(req_remote),
    .gnt_local(gnt_local), .gnt_remote(gnt_remote), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_local = 1'b0; req_remote = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_case(input int dl, input int hl, input int dr, input int hr,
                          output int s1, output int c1, output int f1,
                          output int s2, output int c2);
    bit seen1, fallen, seen2;
    seen1 = 0; fallen = 0; seen2 = 0;
    s1 = 0; c1 = 0; f1 = 0; s2 = 0; c2 = 0;
    for (int t = 0; t < RUN; t++) begin
      @(negedge clk);
      check("R1 exclusive grants", int'(gnt_local && gnt_remote), 0);
      check("R7 busy mirrors grants", int'(busy), int'(gnt_local || gnt_remote));
      if (!seen1 && (gnt_local || gnt_remote)) begin
        seen1 = 1; s1 = gnt_local ? 1 : 2; c1 = t;
      end else if (seen1 && !fallen && !((s1 == 1) ? gnt_local : gnt_remote)) begin
        fallen = 1; f1 = t;
      end
      if (fallen && !seen2 && (gnt_local || gnt_remote)) begin
        seen2 = 1; s2 = gnt_local ? 1 : 2; c2 = t;
      end
      req_local  = (hl > 0) && (t >= dl) && (t < dl + hl);
      req_remote = (hr > 0) && (t >= dr) && (t < dr + hr);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s1, c1, f1, s2, c2;
    // R8: outputs low during and right after reset
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 reset gnt_local", int'(gnt_local), 0);
    check("R8 reset gnt_remote", int'(gnt_remote), 0);
    check("R8 reset busy", int'(busy), 0);

    // table walk: R2 latency, R3 short pulses, R4 release, R5 handover, R6 first tie
    for (int v = 0; v < NV; v++) begin
      do_reset();
      run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], s1, c1, f1, s2, c2);
      check("R2/R3/R6 first grant side", s1, VEC[v][4]);
      check("R2 first grant cycle", c1, VEC[v][5]);
      check("R4 first grant release cycle", f1, VEC[v][6]);
      check("R5 second grant side", s2, VEC[v][7]);
      check("R5 second grant cycle", c2, VEC[v][8]);
    end

    // R6: alternation across ties
    do_reset();
    run_case(0, 6, 0, 10, s1, c1, f1, s2, c2);
    check("R6 first tie after reset goes local", s1, 1);
    check("R6 loser served next", s2, 2);
    run_case(0, 6, 0, 0, s1, c1, f1, s2, c2);
    check("R2 lone local grant", s1, 1);
    run_case(0, 6, 0, 6, s1, c1, f1, s2, c2);
    check("R6 tie after local grant goes remote", s1, 2);
    check("R6 tie remote grant cycle", c1, LAT);

    // R8: asynchronous reset during an active grant
    do_reset();
    @(negedge clk); req_local = 1'b1;
    repeat (LAT + 2) @(negedge clk);
    check("R4 grant held while requested", int'(gnt_local), 1);
    rst_n = 1'b0; req_local = 1'b0;
    #1;
    check("R8 async reset clears grant", int'(gnt_local), 0);
    check("R8 async reset clears busy", int'(busy), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (LAT + 2) @(negedge clk);
    check("R8 idle after reset release", int'(gnt_local || gnt_remote), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule